// File: doc/BRIEF.md
# Flash Reset and Power-Mode Controller

This block is the control logic that sits beside a parallel NOR-style flash array. It decides when the device is in normal operation, when it is being reset through its external active-low reset pin, when it idles in standby, and when it drops into automatic sleep. It does not contain the program/erase engine or the array. It observes the engine's busy flag, can tell the engine to abort, and gates the output drivers, the write-command strobe and the read-valid flag.

A reset pulse on the pin counts only if it lasts long enough. A counted reset aborts any running embedded operation and returns the command decoder to array-read mode. It then holds the device quiet until two things have happened: the internal reset interval has elapsed, and the recovery time after the pin rises has passed. The internal reset interval is longer if an embedded operation was interrupted. Standby follows chip deselect, but never while the engine is busy. Sleep follows a stable address alone, whatever the control strobes do. All times are parameters in clock cycles. The sleep margin is given in nanoseconds and converted using the clock period.

Top module: `flash_pm_ctrl`

## Requirements
- R1: A low level on `rst_pin_n` lasting T_RP or more clock cycles is recognised. Recognition takes effect in the cycle that follows the (T_RP+2)-th rising clock edge after the pin goes low. From that cycle `cmd_accept` is low.
- R2: A low pulse of at most T_RP-1 cycles is ignored. `cmd_accept` stays high, and neither `engine_abort` nor `cmd_clear` is raised.
- R3: In the recognition cycle, `cmd_clear` pulses high for exactly one cycle. In that same cycle, `engine_abort` pulses high for exactly one cycle if `engine_busy` was high.
- R4: From recognition until recovery completes, `dout_en`, `cmd_accept` and `read_ready` are low, whatever `cs_n`, `oe_n` and `we_n` are.
- R5: If `engine_busy` was high at recognition, `ready` is low for T_READY_BUSY cycles starting at the recognition cycle. It is high in the cycle after that window if `engine_busy` is low by then.
- R6: If `engine_busy` was low at recognition, `ready` stays high. The internal reset interval is T_READY_IDLE cycles.
- R7: Normal operation resumes in the later of two cycles. The first is P+3+T_RH, where P is the cycle after whose edge the pin went high. The second is E+L+1, where E is the recognition cycle and L is the applicable internal interval.
- R8: When `cs_n` is high, the synchronised pin is high, the engine is idle and the block is in normal operation, `standby_active` is high from the next cycle. `dout_en` is low while `cs_n` is high, even with `oe_n` low.
- R9: While `engine_busy` is high, `standby_active` stays low. Once `engine_busy` falls with `cs_n` still high, `standby_active` rises one cycle later.
- R10: `sleep_active` rises once the synchronised address has been unchanged for T_ACC + ceil(SLEEP_MARGIN_NS / CLK_NS) cycles. Toggling `cs_n`, `we_n` or `oe_n` neither delays nor prevents it.
- R11: An address change clears `sleep_active` and `read_ready` three cycles after the new value is applied. `read_ready` returns T_ACC cycles after that.
- R12: In normal operation, `dout_en` equals (not `cs_n`) and (not `oe_n`). `cmd_accept` equals (not `cs_n`) and (not `we_n`). Both follow the pins in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| rst_pin_n | input | 1 | External active-low hardware reset pin (asynchronous) |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Address bus (asynchronous) |
| engine_busy | input | 1 | High while the program/erase engine runs |
| ready | output | 1 | Ready/busy: high means ready |
| engine_abort | output | 1 | One-cycle abort request to the engine |
| cmd_clear | output | 1 | One-cycle request to return the command decoder to array-read mode |
| dout_en | output | 1 | Output driver enable; low means high impedance |
| cmd_accept | output | 1 | Gated write-command strobe |
| read_ready | output | 1 | Read data valid |
| sleep_active | output | 1 | Automatic sleep; output data is held |
| standby_active | output | 1 | Standby indicator |

## Verification
The bench targets the pulse-width boundary: exactly T_RP cycles must be recognised and T_RP-1 must not. An off-by-one counter would either miss a real reset or abort an engine on a glitch. It checks that the busy and idle internal intervals are kept apart, and that recovery waits for the later of the internal interval and the post-pin recovery time. A design that keys on only one of them releases reads too early. It also deselects during a busy engine to catch standby entered too soon, and toggles every control strobe while the address is held, to show that sleep depends on the address alone.

// File: rtl/flash_pm_pkg.sv
package flash_pm_pkg;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_HOLD    = 2'd1,
        PH_RECOVER = 2'd2
    } pm_phase_e;

    typedef struct packed {
        logic abort;      // single-cycle abort to engine
        logic cmd_clear;  // single-cycle return to array read
        logic hold_busy;  // keep ready low during embedded-case reset
        logic int_done;   // internal reset interval complete
    } rst_ctl_t;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pm_reset_seq.sv
module pm_reset_seq
    import flash_pm_pkg::*;
#(
    parameter int unsigned T_RP         = 4,
    parameter int unsigned T_READY_BUSY = 20,
    parameter int unsigned T_READY_IDLE = 6,
    parameter int unsigned T_RH         = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_ok,       // synchronised reset pin, high = released
    input  logic      engine_busy,
    output pm_phase_e phase,
    output rst_ctl_t  ctl
);
    localparam int unsigned LOW_W = $clog2(T_RP + 1);
    localparam int unsigned RH_W  = $clog2(T_RH + 1);
    localparam int unsigned TMR_W = $clog2(max_u(T_READY_BUSY, T_READY_IDLE) + 1);
    localparam logic [LOW_W-1:0] LOW_LAST  = LOW_W'(T_RP - 1);
    localparam logic [RH_W-1:0]  RH_LAST   = RH_W'(T_RH - 1);
    localparam logic [TMR_W-1:0] BUSY_LAST = TMR_W'(T_READY_BUSY - 1);
    localparam logic [TMR_W-1:0] IDLE_LAST = TMR_W'(T_READY_IDLE - 1);

    pm_phase_e        phase_q;
    logic [LOW_W-1:0] low_cnt;
    logic [RH_W-1:0]  rh_cnt;
    logic [TMR_W-1:0] tmr;
    logic             busy_case;
    logic             int_done;
    logic             abort_q;
    logic             clr_q;
    logic [TMR_W-1:0] tmr_last;

    assign tmr_last = busy_case ? BUSY_LAST : IDLE_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_RUN;
            low_cnt   <= '0;
            rh_cnt    <= '0;
            tmr       <= '0;
            busy_case <= 1'b0;
            int_done  <= 1'b1;
            abort_q   <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            clr_q   <= 1'b0;
            case (phase_q)
                PH_RUN: begin
                    // R1/R2: pulse-width qualification
                    if (!pin_ok) begin
                        if (low_cnt == LOW_LAST) begin
                            phase_q   <= PH_HOLD;
                            low_cnt   <= '0;
                            abort_q   <= engine_busy;   // R3
                            clr_q     <= 1'b1;          // R3
                            busy_case <= engine_busy;   // R5/R6
                            tmr       <= '0;
                            int_done  <= 1'b0;
                        end else begin
                            low_cnt <= low_cnt + 1'b1;
                        end
                    end else begin
                        low_cnt <= '0;
                    end
                end
                PH_HOLD: begin
                    if (pin_ok) begin
                        phase_q <= PH_RECOVER;
                        rh_cnt  <= '0;
                    end
                end
                PH_RECOVER: begin
                    // R7: recovery after pin release and internal interval
                    if (!pin_ok) begin
                        phase_q <= PH_HOLD;
                    end else if (rh_cnt == RH_LAST && int_done) begin
                        phase_q <= PH_RUN;
                    end else if (rh_cnt != RH_LAST) begin
                        rh_cnt <= rh_cnt + 1'b1;
                    end
                end
                default: phase_q <= PH_RUN;
            endcase

            if (phase_q != PH_RUN && !int_done) begin
                if (tmr == tmr_last) begin
                    int_done <= 1'b1;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    assign phase         = phase_q;
    assign ctl.abort     = abort_q;
    assign ctl.cmd_clear = clr_q;
    assign ctl.hold_busy = (phase_q != PH_RUN) && busy_case && !int_done;
    assign ctl.int_done  = int_done;

    // R2: a released pin never moves the block out of normal operation
    assert_no_entry_on_high_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && pin_ok) |=> (phase_q == PH_RUN));

    // R3: abort and clear are single-cycle pulses
    assert_abort_single_R3: assert property (@(posedge clk) disable iff (rst)
        abort_q |=> !abort_q);
    assert_clear_single_R3: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !clr_q);

    // R7: normal operation never resumes with the internal reset pending
    assert_run_after_internal_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN) |-> int_done);
endmodule

// File: rtl/pm_access_timer.sv
module pm_access_timer #(
    parameter int unsigned AW      = 20,
    parameter int unsigned T_ACC   = 5,
    parameter int unsigned T_SLEEP = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_s,
    output logic          acc_ok,
    output logic          sleep,
    output logic          addr_chg
);
    localparam int unsigned CNT_W = $clog2(T_SLEEP + 1);
    localparam logic [CNT_W-1:0] ACC_LIM   = CNT_W'(T_ACC);
    localparam logic [CNT_W-1:0] SLEEP_LIM = CNT_W'(T_SLEEP);

    logic [AW-1:0]    addr_prev;
    logic [CNT_W-1:0] stable_cnt;

    assign addr_chg = (addr_s != addr_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_prev  <= '0;
            stable_cnt <= '0;
        end else begin
            addr_prev <= addr_s;
            if (addr_chg) begin
                stable_cnt <= '0;
            end else if (stable_cnt != SLEEP_LIM) begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end
    end

    assign acc_ok = (stable_cnt >= ACC_LIM);
    assign sleep  = (stable_cnt == SLEEP_LIM);

    // R11: any change wakes the device and invalidates the read
    assert_wake_on_change_R11: assert property (@(posedge clk) disable iff (rst)
        addr_chg |=> (!sleep && !acc_ok));

    // R10: sleeping data is always valid data
    assert_sleep_keeps_data_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |-> acc_ok);
endmodule

// File: rtl/flash_pm_ctrl.sv
module flash_pm_ctrl
    import flash_pm_pkg::*;
#(
    parameter int unsigned ADDR_W          = 20,
    parameter int unsigned T_RP            = 4,
    parameter int unsigned T_READY_BUSY    = 20,
    parameter int unsigned T_READY_IDLE    = 6,
    parameter int unsigned T_RH            = 3,
    parameter int unsigned T_ACC           = 5,
    parameter int unsigned CLK_NS          = 10,
    parameter int unsigned SLEEP_MARGIN_NS = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              engine_busy,
    output logic              ready,
    output logic              engine_abort,
    output logic              cmd_clear,
    output logic              dout_en,
    output logic              cmd_accept,
    output logic              read_ready,
    output logic              sleep_active,
    output logic              standby_active
);
    localparam int unsigned T_SLEEP = T_ACC + ns_to_cycles(SLEEP_MARGIN_NS, CLK_NS);

    logic              pin_s;
    logic [ADDR_W-1:0] addr_s;
    pm_phase_e         phase;
    rst_ctl_t          ctl;
    logic              acc_ok;
    logic              sleep;
    logic              addr_chg;
    logic              run;
    logic              standby_q;

    pm_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst(rst), .d(rst_pin_n), .q(pin_s)
    );

    pm_sync #(.W(ADDR_W), .RST_VAL('0)) u_addr_sync (
        .clk(clk), .rst(rst), .d(addr), .q(addr_s)
    );

    pm_reset_seq #(
        .T_RP(T_RP), .T_READY_BUSY(T_READY_BUSY),
        .T_READY_IDLE(T_READY_IDLE), .T_RH(T_RH)
    ) u_rst_seq (
        .clk(clk), .rst(rst), .pin_ok(pin_s), .engine_busy(engine_busy),
        .phase(phase), .ctl(ctl)
    );

    pm_access_timer #(.AW(ADDR_W), .T_ACC(T_ACC), .T_SLEEP(T_SLEEP)) u_acc (
        .clk(clk), .rst(rst), .addr_s(addr_s),
        .acc_ok(acc_ok), .sleep(sleep), .addr_chg(addr_chg)
    );

    assign run = (phase == PH_RUN);

    // R8/R9: standby only when deselected, released and idle
    always_ff @(posedge clk) begin
        if (rst) begin
            standby_q <= 1'b0;
        end else begin
            standby_q <= run && cs_n && pin_s && !engine_busy;
        end
    end

    assign ready          = !engine_busy && !ctl.hold_busy;   // R5/R6
    assign engine_abort   = ctl.abort;
    assign cmd_clear      = ctl.cmd_clear;
    assign dout_en        = run && !cs_n && !oe_n;            // R4/R12
    assign cmd_accept     = run && !cs_n && !we_n;            // R4/R12
    assign read_ready     = run && acc_ok;                    // R4/R11
    assign sleep_active   = sleep;                            // R10
    assign standby_active = standby_q;

    // R9: never standby in the cycle after the engine was busy
    assert_no_standby_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $past(engine_busy) |-> !standby_active);

    // R4: reset phases keep drivers off and commands blocked
    assert_quiet_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN) |-> (!dout_en && !cmd_accept && !read_ready));

    // R8: standby with deselect keeps outputs in high impedance
    assert_standby_hiz_R8: assert property (@(posedge clk) disable iff (rst)
        (standby_active && cs_n) |-> !dout_en);

    // R3: the engine is only told to abort while the controller enters reset
    assert_abort_on_entry_R3: assert property (@(posedge clk) disable iff (rst)
        engine_abort |-> (phase == PH_HOLD && cmd_clear));
endmodule

// File: tb/flash_pm_ctrl_tb.sv
module flash_pm_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 20;
    localparam int TRP  = 4;
    localparam int TRB  = 20;
    localparam int TRI  = 6;
    localparam int TRH  = 3;
    localparam int TACC = 5;
    localparam int TSLP = TACC + 3;  // 30 ns at 10 ns per cycle

    logic clk = 1'b0;
    logic rst, rst_pin_n, cs_n, we_n, oe_n, engine_busy;
    logic [AW-1:0] addr;
    logic ready, engine_abort, cmd_clear, dout_en, cmd_accept;
    logic read_ready, sleep_active, standby_active;

    flash_pm_ctrl u_dut (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .engine_busy(engine_busy),
        .ready(ready), .engine_abort(engine_abort), .cmd_clear(cmd_clear),
        .dout_en(dout_en), .cmd_accept(cmd_accept), .read_ready(read_ready),
        .sleep_active(sleep_active), .standby_active(standby_active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_t;
    exp_t sb[$];

    localparam int S_RDY = 0, S_ABT = 1, S_DOE = 2, S_CMD = 3;
    localparam int S_RRD = 4, S_SLP = 5, S_STB = 6, S_CLR = 7;

    function automatic string sig_name(input int s);
        case (s)
            S_RDY: return "ready";
            S_ABT: return "engine_abort";
            S_DOE: return "dout_en";
            S_CMD: return "cmd_accept";
            S_RRD: return "read_ready";
            S_SLP: return "sleep_active";
            S_STB: return "standby_active";
            default: return "cmd_clear";
        endcase
    endfunction

    function automatic logic pick(input int s);
        case (s)
            S_RDY: return ready;
            S_ABT: return engine_abort;
            S_DOE: return dout_en;
            S_CMD: return cmd_accept;
            S_RRD: return read_ready;
            S_SLP: return sleep_active;
            S_STB: return standby_active;
            default: return cmd_clear;
        endcase
    endfunction

    // driver side: push an expected item, keeping the queue ordered by cycle
    function automatic void expect_at(input int at, input int s, input logic v, input string req);
        exp_t item;
        int i;
        item.at = at; item.sig = s; item.val = v; item.req = req;
        i = 0;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, item);
    endfunction

    // monitor side: compare at the falling edge
    always @(negedge clk) begin
        exp_t e;
        if (!done) begin
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                e = sb.pop_front();
                checks++;
                if (e.at < cyc) begin
                    errors++;
                    $display("FAIL %s: %s check at cycle %0d missed (now %0d)",
                             e.req, sig_name(e.sig), e.at, cyc);
                end else if (pick(e.sig) !== e.val) begin
                    errors++;
                    $display("FAIL %s: %s at cycle %0d actual %b expected %b",
                             e.req, sig_name(e.sig), cyc, pick(e.sig), e.val);
                end
            end
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        int n, m, e;
        rst = 1'b1; rst_pin_n = 1'b1; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        addr = '0; engine_busy = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        n = cyc;
        // reset state; R10 sleep from a stable address after reset
        expect_at(n, S_CMD, 1'b1, "R12");
        expect_at(n, S_DOE, 1'b1, "R12");
        expect_at(n, S_ABT, 1'b0, "R3");
        expect_at(n, S_STB, 1'b0, "R8");
        expect_at(n, S_SLP, 1'b0, "R10");
        expect_at(n, S_RDY, 1'b1, "R6");
        expect_at(n, S_RRD, 1'b0, "R11");
        expect_at(n + TACC - 1, S_RRD, 1'b0, "R11");
        expect_at(n + TACC, S_RRD, 1'b1, "R11");
        expect_at(n + TSLP - 1, S_SLP, 1'b0, "R10");
        expect_at(n + TSLP, S_SLP, 1'b1, "R10");
        wait_to(n + 10);

        // R8 / R12: deselect gives standby and high impedance
        n = cyc;
        cs_n = 1'b1;
        expect_at(n, S_DOE, 1'b0, "R8");
        expect_at(n + 1, S_STB, 1'b1, "R8");
        wait_to(n + 3);
        cs_n = 1'b0;
        expect_at(n + 3, S_DOE, 1'b1, "R12");
        expect_at(n + 4, S_STB, 1'b0, "R8");
        wait_to(n + 6);

        // R9: deselect while busy holds off standby
        n = cyc;
        engine_busy = 1'b1; cs_n = 1'b1;
        expect_at(n, S_RDY, 1'b0, "R9");
        expect_at(n + 1, S_STB, 1'b0, "R9");
        expect_at(n + 4, S_STB, 1'b0, "R9");
        expect_at(n + 5, S_STB, 1'b0, "R9");
        expect_at(n + 5, S_RDY, 1'b1, "R9");
        expect_at(n + 6, S_STB, 1'b1, "R9");
        wait_to(n + 5);
        engine_busy = 1'b0;
        wait_to(n + 7);
        cs_n = 1'b0;
        wait_to(n + 9);

        // R10 / R11: sleep independent of strobes, wake on change
        n = cyc;
        addr = 20'h00005;
        expect_at(n + 3, S_SLP, 1'b0, "R11");
        expect_at(n + 3, S_RRD, 1'b0, "R11");
        expect_at(n + 2 + TACC, S_RRD, 1'b0, "R11");
        expect_at(n + 3 + TACC, S_RRD, 1'b1, "R11");
        expect_at(n + 2 + TSLP, S_SLP, 1'b0, "R10");
        expect_at(n + 3 + TSLP, S_SLP, 1'b1, "R10");
        for (int k = 1; k <= 11; k++) begin
            wait_to(n + k);
            cs_n = k[0]; we_n = k[1]; oe_n = ~k[0];
        end
        wait_to(n + 12);
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        wait_to(n + 14);
        m = cyc;
        addr = 20'h00006;
        expect_at(m + 2, S_SLP, 1'b1, "R11");
        expect_at(m + 3, S_SLP, 1'b0, "R11");
        expect_at(m + 2, S_RRD, 1'b1, "R11");
        expect_at(m + 3, S_RRD, 1'b0, "R11");
        wait_to(m + 14);

        // R2: short pulse while busy is ignored
        engine_busy = 1'b1;
        wait_to(cyc + 1);
        n = cyc;
        rst_pin_n = 1'b0;
        expect_at(n + 5, S_CMD, 1'b1, "R2");
        expect_at(n + 6, S_CMD, 1'b1, "R2");
        expect_at(n + 8, S_CMD, 1'b1, "R2");
        expect_at(n + 5, S_ABT, 1'b0, "R2");
        expect_at(n + 6, S_ABT, 1'b0, "R2");
        expect_at(n + 6, S_CLR, 1'b0, "R2");
        wait_to(n + TRP - 1);
        rst_pin_n = 1'b1;
        wait_to(n + 12);

        // R1 R3 R4 R5 R7: long reset during an embedded operation
        n = cyc;
        e = n + TRP + 2;
        rst_pin_n = 1'b0;
        expect_at(e - 1, S_CMD, 1'b1, "R1");
        expect_at(e, S_CMD, 1'b0, "R1");
        expect_at(e - 1, S_ABT, 1'b0, "R3");
        expect_at(e, S_ABT, 1'b1, "R3");
        expect_at(e + 1, S_ABT, 1'b0, "R3");
        expect_at(e, S_CLR, 1'b1, "R3");
        expect_at(e + 1, S_CLR, 1'b0, "R3");
        expect_at(e, S_DOE, 1'b0, "R4");
        expect_at(e, S_RRD, 1'b0, "R4");
        expect_at(e, S_RDY, 1'b0, "R5");
        expect_at(e + 10, S_RDY, 1'b0, "R5");
        expect_at(e + TRB - 1, S_RDY, 1'b0, "R5");
        expect_at(e + TRB, S_RDY, 1'b1, "R5");
        expect_at(e + TRB, S_CMD, 1'b0, "R7");
        expect_at(e + TRB, S_DOE, 1'b0, "R4");
        expect_at(e + TRB + 1, S_CMD, 1'b1, "R7");
        expect_at(e + TRB + 1, S_DOE, 1'b1, "R7");
        expect_at(e + TRB + 1, S_RRD, 1'b1, "R7");
        wait_to(e);
        engine_busy = 1'b0;
        wait_to(n + 10);
        rst_pin_n = 1'b1;
        wait_to(e + TRB + 4);

        // R6 R7: long reset while idle, recovery bounded by pin release
        n = cyc;
        e = n + TRP + 2;
        rst_pin_n = 1'b0;
        expect_at(e, S_RDY, 1'b1, "R6");
        expect_at(e + 3, S_RDY, 1'b1, "R6");
        expect_at(e, S_ABT, 1'b0, "R6");
        expect_at(e, S_CLR, 1'b1, "R3");
        expect_at(e, S_CMD, 1'b0, "R4");
        expect_at(n + 10 + 3 + TRH - 1, S_CMD, 1'b0, "R7");
        expect_at(n + 10 + 3 + TRH - 1, S_RRD, 1'b0, "R7");
        expect_at(n + 10 + 3 + TRH, S_CMD, 1'b1, "R7");
        expect_at(n + 10 + 3 + TRH, S_RRD, 1'b1, "R7");
        wait_to(n + 10);
        rst_pin_n = 1'b1;
        wait_to(n + 20);

        // R1 boundary: exactly T_RP cycles low is recognised
        n = cyc;
        e = n + TRP + 2;
        rst_pin_n = 1'b0;
        expect_at(e - 1, S_CMD, 1'b1, "R1");
        expect_at(e, S_CMD, 1'b0, "R1");
        expect_at(e, S_CLR, 1'b1, "R1");
        expect_at(e + TRI, S_CMD, 1'b0, "R7");
        expect_at(e + TRI + 1, S_CMD, 1'b1, "R7");
        wait_to(n + TRP);
        rst_pin_n = 1'b1;
        wait_to(e + TRI + 4);

        done = 1;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d scoreboard items left, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R1: watchdog expired at cycle %0d, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule